// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the program counter of a processor whose instructions are all 32 bits wide and works out, every cycle, where the next instruction comes from. It has four sources to choose from. The first is straight-line flow, four bytes on. The second is a conditional branch relative to the incremented PC. The third is a direct jump that splices a 26-bit index into the current 256 MiB region. The fourth is a jump to an address read from a register.

The decode stage drives the control inputs and the immediate fields. The register file drives the two compare operands and the register target. The block answers with the combinational next address and with the return address for a call. It loads the next address into its PC register on every clock edge. A call is a direct jump whose decoder also writes `link_addr` into register 31. Fetch, decode and the register file sit outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc_q` is loaded with the parameter `RESET_VEC` (default 0x0000_0400), whatever the control inputs are.
- R2: With `br_en`, `jmp_en` and `jreg_en` all low, `next_pc` equals `pc_q + 4`.
- R3: With `br_en` high and `br_ne` low, the branch is taken when `cmp_a == cmp_b`. The target is `pc_q + 4 + (sign-extended br_imm << 2)`.
- R4: With `br_en` high and `br_ne` high, the branch is taken when `cmp_a != cmp_b`, to the same target as in R3.
- R5: A branch whose condition fails gives `next_pc = pc_q + 4`. When `br_en` is low, the operands and `br_imm` have no effect.
- R6: `br_imm` is two's complement, so a negative offset lands below `pc_q + 4`. This holds down to 0x8000 (−32768 words), and the sum wraps modulo 2^32.
- R7: With `jmp_en` high, `next_pc = {pc_q[31:28], jmp_idx, 2'b00}`.
- R8: With `jreg_en` high, `next_pc = reg_tgt`, unchanged.
- R9: Fixed priority: `jreg_en` over `jmp_en`, then `jmp_en` over a taken branch, then a taken branch over sequential flow.
- R10: `link_addr` always equals `pc_q + 4`, the address after the current instruction.
- R11: Out of reset, each rising clock edge loads `pc_q` with the `next_pc` value that stood just before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| br_imm | input | IMM_W (16) | Branch word offset, two's complement |
| jmp_idx | input | IDX_W (26) | Direct jump word index |
| reg_tgt | input | XLEN (32) | Register value for the register-indirect jump |
| br_en | input | 1 | Current instruction is a conditional branch |
| br_ne | input | 1 | 0: branch on equal operands, 1: branch on different operands |
| cmp_a | input | XLEN (32) | First compare operand |
| cmp_b | input | XLEN (32) | Second compare operand |
| jmp_en | input | 1 | Current instruction is a direct jump or call |
| jreg_en | input | 1 | Current instruction jumps to `reg_tgt` |
| pc_q | output | XLEN (32) | Current program counter |
| next_pc | output | XLEN (32) | Address of the next instruction, combinational |
| link_addr | output | XLEN (32) | Return address for a call |

## Verification
The embedded properties assume that the control inputs are settled well before each rising edge and are free of X and Z. The region property also assumes that `pc_q` stays word-aligned, which follows from an aligned `RESET_VEC` and aligned register targets. The bench meets these assumptions. It changes every input on the falling edge, reads `next_pc` and `link_addr` one nanosecond later, and reads `pc_q` one nanosecond after the next rising edge. Each vector sets its starting PC with a register jump to a word-aligned base, so the aligned-PC assumption holds throughout. The operand pairs cover equal values, different values and an unused compare.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared types for the next-instruction-address unit.
// Assumes nothing beyond the users importing it.
package npc_pkg;

    // Which source feeds the next program counter.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2,
        SRC_JREG   = 2'd3
    } pc_src_e;

endpackage

// File: rtl/npc_targets.sv
// Module npc_targets
// Forms every candidate address from the current PC and the immediates:
// the sequential address (also the return address), the PC-relative branch
// target and the region-relative direct jump target.
// Assumes XLEN > IMM_W + SHIFT and XLEN > IDX_W + SHIFT.
module npc_targets #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 26,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [IDX_W-1:0] idx,
    output logic [XLEN-1:0]  seq_tgt,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt
);
    localparam int EXT_W = XLEN - IMM_W - SHIFT;
    localparam int REG_W = XLEN - IDX_W - SHIFT;
    localparam logic [XLEN-1:0] STEP = XLEN'(1) << SHIFT;

    logic [XLEN-1:0] byte_off;

    // Sign-extend the word offset and scale it to bytes.
    always_comb begin
        byte_off = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
    end

    // Sequential address and branch target built on top of it.
    always_comb begin
        seq_tgt = pc + STEP;
        br_tgt  = seq_tgt + byte_off;
    end

    // Keep the PC region bits and replace the rest with the scaled index.
    always_comb begin
        jmp_tgt = {pc[XLEN-1 -: REG_W], idx, {SHIFT{1'b0}}};
    end

endmodule

// File: rtl/npc_branch_cmp.sv
// Module npc_branch_cmp
// Decides whether a conditional branch is taken: on equal operands when
// ne_mode is low, on differing operands when it is high.
// Assumes the operands are the fully forwarded register values.
module npc_branch_cmp #(
    parameter int XLEN = 32
) (
    input  logic            en,
    input  logic            ne_mode,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            taken
);
    logic [XLEN-1:0] diff_bits;
    logic            same;

    // Bitwise difference, then a reduction to a single equality flag.
    always_comb begin
        diff_bits = op_a ^ op_b;
        same      = ~|diff_bits;
    end

    // Taken only when a branch is present and its condition holds.
    always_comb begin
        taken = en & (same ^ ne_mode);
    end

endmodule

// File: rtl/npc_priority.sv
// Module npc_priority
// Fixed-priority choice of the PC source: register jump, then direct jump,
// then a taken branch, otherwise sequential flow.
// Assumes the decoder may raise several requests at once.
module npc_priority
    import npc_pkg::*;
(
    input  logic    jreg_req,
    input  logic    jump_req,
    input  logic    br_taken,
    output pc_src_e src
);
    // Priority chain, highest first.
    always_comb begin
        if (jreg_req)      src = SRC_JREG;
        else if (jump_req) src = SRC_JUMP;
        else if (br_taken) src = SRC_BRANCH;
        else               src = SRC_SEQ;
    end

endmodule

// File: rtl/npc_unit.sv
// Module npc_unit
// Holds the program counter and selects the next instruction address among
// sequential, branch, direct jump and register jump. Also presents the
// return address used by calls.
// Assumes controls are stable before each rising edge; the reset is
// synchronous and active low; RESET_VEC is word aligned.
module npc_unit
    import npc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              IMM_W     = 16,
    parameter int              IDX_W     = 26,
    parameter int              INSTR_B   = 4,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IMM_W-1:0] br_imm,
    input  logic [IDX_W-1:0] jmp_idx,
    input  logic [XLEN-1:0]  reg_tgt,
    input  logic             br_en,
    input  logic             br_ne,
    input  logic [XLEN-1:0]  cmp_a,
    input  logic [XLEN-1:0]  cmp_b,
    input  logic             jmp_en,
    input  logic             jreg_en,
    output logic [XLEN-1:0]  pc_q,
    output logic [XLEN-1:0]  next_pc,
    output logic [XLEN-1:0]  link_addr
);
    localparam int SHIFT = $clog2(INSTR_B);
    localparam int REG_W = XLEN - IDX_W - SHIFT;
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_B);

    logic [XLEN-1:0] seq_tgt;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;
    logic            br_taken;
    pc_src_e         src;

    npc_targets #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W),
        .IDX_W (IDX_W),
        .SHIFT (SHIFT)
    ) u_targets (
        .pc      (pc_q),
        .imm     (br_imm),
        .idx     (jmp_idx),
        .seq_tgt (seq_tgt),
        .br_tgt  (br_tgt),
        .jmp_tgt (jmp_tgt)
    );

    npc_branch_cmp #(
        .XLEN (XLEN)
    ) u_cmp (
        .en      (br_en),
        .ne_mode (br_ne),
        .op_a    (cmp_a),
        .op_b    (cmp_b),
        .taken   (br_taken)
    );

    npc_priority u_prio (
        .jreg_req (jreg_en),
        .jump_req (jmp_en),
        .br_taken (br_taken),
        .src      (src)
    );

    // Route the chosen candidate to the next-address output.
    always_comb begin
        unique case (src)
            SRC_JREG:   next_pc = reg_tgt;
            SRC_JUMP:   next_pc = jmp_tgt;
            SRC_BRANCH: next_pc = br_tgt;
            default:    next_pc = seq_tgt;
        endcase
    end

    // The return address is the instruction after the current one.
    always_comb begin
        link_addr = seq_tgt;
    end

    // PC register: reset vector on reset, else the selected address.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_VEC;
        else        pc_q <= next_pc;
    end

    // Properties guarding the selection and the register.
    AST_PC_LOADS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc_q == $past(next_pc));                          // R11
    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_en && !jmp_en && !jreg_en) |-> next_pc == pc_q + STEP);       // R2
    AST_JREG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        jreg_en |-> next_pc == reg_tgt);                                   // R9
    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_en && !jreg_en) |->
            (next_pc[XLEN-1 -: REG_W] == pc_q[XLEN-1 -: REG_W]
             && next_pc[IDX_W+SHIFT-1 -: IDX_W] == jmp_idx));              // R7
    AST_FAILED_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && !jmp_en && !jreg_en && ((cmp_a == cmp_b) == br_ne))
            |-> next_pc == link_addr);                                     // R5

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    localparam real             CLK_PERIOD = 5.0;
    localparam logic [31:0]     RST_VEC    = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] br_imm;
    logic [25:0] jmp_idx;
    logic [31:0] reg_tgt;
    logic        br_en, br_ne, jmp_en, jreg_en;
    logic [31:0] cmp_a, cmp_b;
    logic [31:0] pc_q, next_pc, link_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    npc_unit #(.RESET_VEC(RST_VEC)) u_npc_unit (
        .clk(clk), .rst_n(rst_n), .br_imm(br_imm), .jmp_idx(jmp_idx),
        .reg_tgt(reg_tgt), .br_en(br_en), .br_ne(br_ne), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .jmp_en(jmp_en), .jreg_en(jreg_en), .pc_q(pc_q),
        .next_pc(next_pc), .link_addr(link_addr)
    );

    // ctl = {jreg_en, jmp_en, br_en, br_ne}
    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] base;
        logic [15:0] imm;
        logic [25:0] idx;
        logic [31:0] rtg;
        logic [3:0]  ctl;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'd2, 32'h0000_1000, 16'h0000, 26'h0,       32'h0,         4'b0000, 32'd0, 32'd0, 32'h0000_1004}, // R2
        '{8'd3, 32'h0000_1000, 16'h0010, 26'h0,       32'h0,         4'b0010, 32'd7, 32'd7, 32'h0000_1044}, // R3
        '{8'd5, 32'h0000_1000, 16'h0010, 26'h0,       32'h0,         4'b0010, 32'd7, 32'd8, 32'h0000_1004}, // R5
        '{8'd4, 32'h0000_1000, 16'h0003, 26'h0,       32'h0,         4'b0011, 32'd1, 32'd2, 32'h0000_1010}, // R4
        '{8'd5, 32'h0000_1000, 16'h0003, 26'h0,       32'h0,         4'b0011, 32'd5, 32'd5, 32'h0000_1004}, // R5
        '{8'd5, 32'h0000_1000, 16'h0040, 26'h0,       32'h0,         4'b0000, 32'd9, 32'd9, 32'h0000_1004}, // R5 branch absent
        '{8'd6, 32'h0000_2000, 16'hFFFE, 26'h0,       32'h0,         4'b0010, 32'd3, 32'd3, 32'h0000_1FFC}, // R6
        '{8'd6, 32'h0004_0000, 16'h8000, 26'h0,       32'h0,         4'b0010, 32'd0, 32'd0, 32'h0002_0004}, // R6
        '{8'd6, 32'h0000_0008, 16'hFFF0, 26'h0,       32'h0,         4'b0011, 32'd1, 32'd0, 32'hFFFF_FFCC}, // R6
        '{8'd7, 32'hA000_0100, 16'h0000, 26'h0123456, 32'h0,         4'b0100, 32'd0, 32'd0, 32'hA048_D158}, // R7
        '{8'd7, 32'h5000_0000, 16'h0000, 26'h3FFFFFF, 32'h0,         4'b0100, 32'd0, 32'd0, 32'h5FFF_FFFC}, // R7
        '{8'd7, 32'hF000_0000, 16'h0000, 26'h0,       32'h0,         4'b0100, 32'd0, 32'd0, 32'hF000_0000}, // R7
        '{8'd8, 32'h0000_0100, 16'h0000, 26'h0,       32'h1234_5678, 4'b1000, 32'd0, 32'd0, 32'h1234_5678}, // R8
        '{8'd9, 32'h0000_0100, 16'h0010, 26'h0000010, 32'hDEAD_BEE0, 4'b1110, 32'd4, 32'd4, 32'hDEAD_BEE0}, // R9
        '{8'd9, 32'h3000_0000, 16'h0010, 26'h0000010, 32'h0,         4'b0110, 32'd4, 32'd4, 32'h3000_0040}  // R9
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        br_imm = '0; jmp_idx = '0; reg_tgt = '0; cmp_a = '0; cmp_b = '0;
        br_en = 1'b0; br_ne = 1'b0; jmp_en = 1'b0; jreg_en = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        // Move the PC to the row's base through a register jump.
        @(negedge clk);
        idle_inputs();
        jreg_en = 1'b1; reg_tgt = v.base;
        @(negedge clk);
        br_imm = v.imm; jmp_idx = v.idx; reg_tgt = v.rtg;
        {jreg_en, jmp_en, br_en, br_ne} = v.ctl;
        cmp_a = v.a; cmp_b = v.b;
        #1;
        check(tag, next_pc, v.exp);
        check("R10", link_addr, v.base + 32'd4);
        @(posedge clk);
        #1;
        check("R11", pc_q, v.exp);
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (2) @(posedge clk);
        #1;
        check("R1", pc_q, RST_VEC);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2", next_pc, RST_VEC + 32'd4);
        @(posedge clk);
        #1;
        check("R11", pc_q, RST_VEC + 32'd4);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset wins over an active register jump.
        @(negedge clk);
        rst_n = 1'b0; jreg_en = 1'b1; reg_tgt = 32'h7777_0000; jmp_en = 1'b1;
        @(posedge clk);
        #1;
        check("R1", pc_q, RST_VEC);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R2", pc_q, RST_VEC + 32'd4);

        // R10: link address follows the PC on a call.
        @(negedge clk);
        jmp_en = 1'b1; jmp_idx = 26'h0000100;
        #1;
        check("R10", link_addr, RST_VEC + 32'd8);
        check("R7", next_pc, 32'h0000_0400);
        @(negedge clk);
        idle_inputs();

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000.0);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule